// File: doc/BRIEF.md
# Selectable Edge Clock Front End

This block produces the advance enable for a timer counter and conditions the event inputs that later event logic reads. Everything runs on the bus clock. A two-bit mode field picks how the counter is paced: on every bus cycle, or only on a chosen edge of one of the four lower inputs. The input that paces the counter can be used in two ways. The high-performance sampled mode and the low-power input-clocked mode both appear here as a one-cycle tick enable in the bus clock domain. No clock is actually switched.

A single four-bit select code names both the pacing input and its edge. Bits 2:1 of the code give the input number and bit 0 gives the polarity: 0 means rising and 1 means falling. Each of the eight event inputs has its own two-flop synchronizer. A mask bit chooses whether that input's conditioned output passes through the synchronizer or goes around it for lower latency. When a sampled mode is active, the pacing input is always synchronized and its mask bit has no effect.

Top module: `edge_tick_frontend`

## Requirements
- R1: With mode 0, `tick_o` is 1 on every bus cycle after reset, starting at the first rising edge after reset is released.
- R2: With mode 1 and a valid select code, `tick_o` pulses high for exactly one cycle for each chosen edge on the chosen input. The pulse comes in the third cycle after the input changes, counted as three rising clock edges. Edges on other inputs give no pulse.
- R3: Mode 2 gives the same pulse as mode 1: one tick per chosen edge, three edges after the input change.
- R4: The select code maps to input = code[2:1]. code[0] = 0 picks rising edges and code[0] = 1 picks falling edges.
- R5: Mode 3 produces no ticks, whatever the inputs do.
- R6: In modes 1 and 2, select codes 8 to 15 produce no ticks.
- R7: When its mask bit is 1, `cond_o[i]` follows `in_i[i]` three clock edges late, through a two-flop synchronizer and the output register. When the bit is 0, `cond_o[i]` follows one edge late.
- R8: In modes 1 and 2, the input named by a valid select code is conditioned with the three-edge synchronized latency, whatever its mask bit says. In mode 0, the mask bit decides.
- R9: While `rst` is high, `tick_o` and `cond_o` are 0 at the next rising edge, regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| in_i | input | 8 | Raw event inputs; the lower four can pace the counter |
| mode_i | input | 2 | Pacing mode: 0 bus, 1 sampled edge, 2 input-clocked, 3 reserved |
| sel_i | input | 4 | Pacing input and edge code |
| sync_mask_i | input | 8 | Per-input synchronizer enable, bit i for input i |
| tick_o | output | 1 | Registered counter advance enable |
| cond_o | output | 8 | Registered conditioned event inputs |

## Verification
The assertions assume three things about the inputs. Each level on a pacing input lasts at least one bus cycle. Mode and select stay constant while an edge travels through the pipeline. Every input is low at reset release, so no edge is detected falsely. The stimulus follows all three. It changes inputs only at falling clock edges and holds pulses for several cycles. Before each new configuration it lowers every input and waits for the pipeline to drain.

// File: rtl/edge_fe_pkg.sv
package edge_fe_pkg;
  typedef enum logic [1:0] {
    PACE_BUS     = 2'd0,
    PACE_SAMPLED = 2'd1,
    PACE_INPUT   = 2'd2,
    PACE_RSVD    = 2'd3
  } pace_mode_e;

  function automatic logic is_edge_mode(input logic [1:0] m);
    return (m == PACE_SAMPLED) || (m == PACE_INPUT);
  endfunction
endpackage

// File: rtl/in_sync_bank.sv
module in_sync_bank #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] raw_i,
  input  logic [N_IN-1:0] use_sync_i,
  output logic [N_IN-1:0] synced_o,
  output logic [N_IN-1:0] cond_o
);
  logic [N_IN-1:0] stage1_q, stage2_q, cond_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
        cond_q[i]   <= 1'b0;
      end else begin
        stage1_q[i] <= raw_i[i];
        stage2_q[i] <= stage1_q[i];
        cond_q[i]   <= use_sync_i[i] ? stage2_q[i] : raw_i[i];
      end
    end

    // Bypassed lane mirrors the raw input one edge later (R7)
    assert_bypass_latency_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(use_sync_i[i])) |-> (cond_o[i] == $past(raw_i[i])));
  end

  assign synced_o = stage2_q;
  assign cond_o   = cond_q;
endmodule

// File: rtl/edge_sel_detect.sv
module edge_sel_detect #(
  parameter int N_CLK_IN = 4,
  parameter int SEL_W    = 4,
  localparam int IDX_W   = (N_CLK_IN > 1) ? $clog2(N_CLK_IN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_CLK_IN-1:0] synced_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                sel_valid_o,
  output logic                edge_hit_o
);
  localparam int N_CODES = 2 * N_CLK_IN;

  logic cur, prev_q, falling_pick;

  assign idx_o        = sel_i[IDX_W:1];
  assign falling_pick = sel_i[0];
  assign sel_valid_o  = (int'(sel_i) < N_CODES);
  assign cur          = synced_i[idx_o];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  assign edge_hit_o = falling_pick ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/tick_gen.sv
module tick_gen
  import edge_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       sel_valid_i,
  input  logic       edge_hit_i,
  output logic       tick_o
);
  logic tick_q, next_tick;

  always_comb begin
    unique case (pace_mode_e'(mode_i))
      PACE_BUS:                 next_tick = 1'b1;
      PACE_SAMPLED, PACE_INPUT: next_tick = sel_valid_i & edge_hit_i;
      default:                  next_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= next_tick;
  end

  assign tick_o = tick_q;

  assert_bus_every_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) == 2'd0) |-> tick_o);
  assert_reserved_mode_silent_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) == 2'd3) |-> !tick_o);
endmodule

// File: rtl/edge_tick_frontend.sv
module edge_tick_frontend
  import edge_fe_pkg::*;
#(
  parameter int N_IN     = 8,
  parameter int N_CLK_IN = 4,
  parameter int SEL_W    = 4,
  localparam int IDX_W   = (N_CLK_IN > 1) ? $clog2(N_CLK_IN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] in_i,
  input  logic [1:0]      mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_IN-1:0] sync_mask_i,
  output logic            tick_o,
  output logic [N_IN-1:0] cond_o
);
  logic [N_IN-1:0]  synced, use_sync;
  logic [IDX_W-1:0] idx;
  logic             sel_valid, edge_hit, edge_mode;

  assign edge_mode = is_edge_mode(mode_i);

  // The pacing input always keeps its synchronizer in edge modes
  for (genvar i = 0; i < N_IN; i++) begin : g_use
    if (i < N_CLK_IN) begin : g_clk_cap
      assign use_sync[i] = sync_mask_i[i] |
                           (edge_mode & sel_valid & (int'(idx) == i));
    end else begin : g_plain
      assign use_sync[i] = sync_mask_i[i];
    end
  end

  in_sync_bank #(.N_IN(N_IN)) u_sync (
    .clk(clk), .rst(rst), .raw_i(in_i), .use_sync_i(use_sync),
    .synced_o(synced), .cond_o(cond_o)
  );

  edge_sel_detect #(.N_CLK_IN(N_CLK_IN), .SEL_W(SEL_W)) u_edge (
    .clk(clk), .rst(rst), .synced_i(synced[N_CLK_IN-1:0]), .sel_i(sel_i),
    .idx_o(idx), .sel_valid_o(sel_valid), .edge_hit_o(edge_hit)
  );

  tick_gen u_tick (
    .clk(clk), .rst(rst), .mode_i(mode_i), .sel_valid_i(sel_valid),
    .edge_hit_i(edge_hit), .tick_o(tick_o)
  );

  assert_edge_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && edge_mode && $stable(mode_i) && $stable(sel_i)) |=>
      (!tick_o || !$stable(mode_i) || !$stable(sel_i)));
  assert_reserved_code_silent_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(edge_mode) && !$past(sel_valid)) |-> !tick_o);
  assert_reset_clears_R9: assert property (@(posedge clk)
    $past(rst) |-> (!tick_o && cond_o == '0));
endmodule

// File: tb/edge_tick_frontend_tb.sv
`timescale 1ns/1ps
module edge_tick_frontend_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_i = '0;
  logic [1:0] mode_i = '0;
  logic [3:0] sel_i = '0;
  logic [7:0] sync_mask_i = 8'hFF;
  logic       tick_o;
  logic [7:0] cond_o;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  edge_tick_frontend dut_i (
    .clk(clk), .rst(rst), .in_i(in_i), .mode_i(mode_i), .sel_i(sel_i),
    .sync_mask_i(sync_mask_i), .tick_o(tick_o), .cond_o(cond_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt, first, lat, exp_cnt, exp_first, exp_lat;
    bit selected;
    // R9: reset forces outputs low even with inputs high
    @(negedge clk);
    in_i = 8'hFF;
    idle(3);
    chk("R9 tick in reset", int'(tick_o), 0);
    chk("R9 cond in reset", int'(cond_o), 0);
    in_i = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R1 first tick after reset", int'(tick_o), 1);

    // R1..R6: sweep mode, select code, pulsed input
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int k = 0; k < 4; k++) begin
          mode_i = m[1:0];
          sel_i  = s[3:0];
          in_i   = '0;
          idle(5);
          in_i[k] = 1'b1;
          cnt = 0; first = 0;
          for (int c = 1; c <= 12; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick_o) begin
              cnt++;
              if (first == 0) first = c;
            end
            if (c == 4) in_i[k] = 1'b0;
          end
          if (m == 0) begin
            exp_cnt = 12; exp_first = 1;
          end else if (m == 3 || s >= 8 || (s / 2) != k) begin
            exp_cnt = 0; exp_first = 0;
          end else begin
            exp_cnt = 1; exp_first = (s % 2 == 0) ? 3 : 7;
          end
          if (m == 0)
            chk($sformatf("R1 count m%0d s%0d k%0d", m, s, k), cnt, exp_cnt);
          else if (m == 3)
            chk($sformatf("R5 count s%0d k%0d", s, k), cnt, exp_cnt);
          else if (s >= 8)
            chk($sformatf("R6 count m%0d s%0d k%0d", m, s, k), cnt, exp_cnt);
          else if (m == 1)
            chk($sformatf("R2 R4 count s%0d k%0d", s, k), cnt, exp_cnt);
          else
            chk($sformatf("R3 R4 count s%0d k%0d", s, k), cnt, exp_cnt);
          chk($sformatf("R4 first tick m%0d s%0d k%0d", m, s, k), first, exp_first);
        end
      end
    end

    // R7, R8: conditioned output latency
    for (int i = 0; i < 8; i++) begin
      for (int mb = 0; mb < 2; mb++) begin
        for (int m = 0; m < 3; m++) begin
          mode_i = m[1:0];
          sel_i  = 4'((i % 4) * 2);
          sync_mask_i = mb ? 8'hFF : 8'h00;
          in_i = '0;
          idle(5);
          in_i[i] = 1'b1;
          lat = 0;
          for (int c = 1; c <= 6; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (cond_o[i] && lat == 0) lat = c;
          end
          selected = (m != 0) && (i < 4);
          exp_lat = (mb == 1 || selected) ? 3 : 1;
          if (selected && mb == 0)
            chk($sformatf("R8 latency in%0d m%0d", i, m), lat, exp_lat);
          else
            chk($sformatf("R7 latency in%0d mask%0d m%0d", i, mb, m), lat, exp_lat);
          in_i = '0;
        end
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule